// File: doc/BRIEF.md
# Four-Channel Buffered Pulse-Width Modulator

This block drives a set of pulse-width modulated outputs. Each channel has a clock prescaler, a period counter and a polarity select. Its waveform is defined by two numbers. The period is the number of counts in one cycle. The duty value is the number of counts the pin spends at its inactive level before it switches to the active level for the rest of the cycle. Every period starts at the inactive level.

Software controls the block through a simple 32-bit register bus. The bus has write and read strobes, a byte address and a data word, and read data comes back registered one clock after the strobe. While a channel is stopped, its live settings can be written directly. While it runs, new duty and period values go into separate update registers. The channel copies them into the live settings only when the current period ends, so no period is ever cut short or stretched.

Stopping a channel also waits for the period boundary. The channel status bit stays set until the channel has really stopped. A per-channel end-of-period flag collects in an interrupt status word, which clears when it is read.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output pin is 0, and the status, interrupt status, mode, duty and period registers all read 0.
- R2: Global registers sit at byte addresses 0x04 (enable), 0x08 (disable), 0x0C (status) and 0x1C (interrupt status), and bit n of each refers to channel n. Channel n's bank starts at 0x200 + n*0x20, with the following offsets inside the bank: mode 0x00, duty 0x04, duty update 0x08, period 0x0C, period update 0x10.
- R3: Mode bits [3:0] hold the prescale exponent p, and the channel counter advances once every 2^p clocks. A written value above 10 is stored and read back as 10.
- R4: A period lasts P counts. P = 0 behaves as P = 1. While the counter is below the duty value D the pin is inactive; from D onward it is active. The active time is therefore (P - D) counts, and the pin is never active when D >= P.
- R5: Mode bit 9 is the polarity. With 0 the inactive level is low and the active level is high; with 1 both are inverted. A stopped channel holds its inactive level.
- R6: Duty and period values are 16 bits wide, and the upper bits of a write are dropped.
- R7: A value written to a duty-update or period-update register does not show in the live register until the end of the channel's current period. From that boundary on it is both live and readable.
- R8: Writes to the live mode, duty or period register take effect at once while the channel is stopped. While the channel runs they are ignored.
- R9: Writing 1 to bit n of the enable register starts a stopped channel n from count 0, and its status bit reads 1.
- R10: Writing 1 to bit n of the disable register stops channel n only at the end of its current period. The status bit stays 1 until then, and afterwards the pin returns to the inactive level.
- R11: Interrupt status bit n is set at every end of period of channel n. Reading the interrupt status register returns its value and clears it; an event in the same cycle as the read is kept.
- R12: Reads of unmapped addresses, and of the two update registers, return 0. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; data returns on rdata after the next edge |
| addr | input | ADDR_W (12) | Byte address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| pwm_out | output | NCH (4) | Channel output pins |

## Verification
The hardest situations to reach from the ports are the moments just before and just after a period boundary while a change is pending. These are a buffered duty or period value that must not yet be live, and a disable request that must not yet have stopped the channel. The bench uses the interrupt status register as a boundary marker. It clears the flag, polls until the channel's bit reappears, and then has almost a whole period left in which to write an update or a disable. It reads the live registers and the status bit inside that period, and again after the next flag. The waveform itself is checked with a sweep over prescaler, period, duty and polarity. For each setting the bench counts high cycles and rising edges over a window of whole periods, which gives results that do not depend on the output's phase.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // global register byte offsets
  localparam int OFS_ENA    = 'h004;
  localparam int OFS_DIS    = 'h008;
  localparam int OFS_STAT   = 'h00C;
  localparam int OFS_EVT    = 'h01C;
  // per-channel bank layout
  localparam int BANK_BASE  = 'h200;
  localparam int BANK_SH    = 5;           // 32-byte stride
  localparam int BOFS_MODE  = 'h00;
  localparam int BOFS_DUTY  = 'h04;
  localparam int BOFS_DNXT  = 'h08;
  localparam int BOFS_PER   = 'h0C;
  localparam int BOFS_PNXT  = 'h10;
  // mode word fields
  localparam int POL_BIT    = 9;
endpackage

// File: rtl/pwm_bank_presc.sv
module pwm_bank_presc #(
  parameter int PRES_W   = 4,
  parameter int PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [PRES_W-1:0] pres,
  output logic              tick
);
  localparam int DIV_W = PRES_MAX + 1;

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] lim;

  assign lim  = (DIV_W'(1) << pres) - DIV_W'(1);
  assign tick = !hold && (div == lim);

  always_ff @(posedge clk) begin
    if (rst || hold || tick) div <= '0;
    else                     div <= div + DIV_W'(1);
  end

  // R3: divider never runs past the selected terminal count
  p_div_bound_r3: assert property (@(posedge clk) disable iff (rst)
    !hold |-> div <= lim);
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
  parameter int CNT_W    = 16,
  parameter int PRES_W   = 4,
  parameter int PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ena_req,
  input  logic              dis_req,
  input  logic              wr_mode,
  input  logic              wr_duty,
  input  logic              wr_per,
  input  logic              wr_dnxt,
  input  logic              wr_pnxt,
  input  logic [CNT_W-1:0]  wval,
  input  logic [PRES_W-1:0] wpres,
  input  logic              wpol,
  output logic              running,
  output logic              eop,
  output logic              pol,
  output logic [PRES_W-1:0] pres,
  output logic [CNT_W-1:0]  duty,
  output logic [CNT_W-1:0]  period,
  output logic              pin
);
  localparam logic [PRES_W-1:0] PRES_TOP = PRES_W'(PRES_MAX);

  logic             tick;
  logic             stop_pend;
  logic             dnxt_v, pnxt_v;
  logic [CNT_W-1:0] cnt, dnxt, pnxt;
  logic [CNT_W:0]   cnt_inc;
  logic             at_end;

  pwm_bank_presc #(.PRES_W(PRES_W), .PRES_MAX(PRES_MAX)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .hold (~running),
    .pres (pres),
    .tick (tick)
  );

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign at_end  = cnt_inc >= {1'b0, period};
  assign eop     = running && tick && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      stop_pend <= 1'b0;
      pol       <= 1'b0;
      pres      <= '0;
      duty      <= '0;
      period    <= '0;
      cnt       <= '0;
      dnxt      <= '0;
      pnxt      <= '0;
      dnxt_v    <= 1'b0;
      pnxt_v    <= 1'b0;
      pin       <= 1'b0;
    end else begin
      if (!running) begin
        if (wr_mode) begin
          pres <= (wpres > PRES_TOP) ? PRES_TOP : wpres;
          pol  <= wpol;
        end
        if (wr_duty) duty   <= wval;
        if (wr_per)  period <= wval;
      end
      if (running && tick) cnt <= at_end ? '0 : cnt_inc[CNT_W-1:0];
      if (eop) begin
        if (dnxt_v) begin duty   <= dnxt; dnxt_v <= 1'b0; end
        if (pnxt_v) begin period <= pnxt; pnxt_v <= 1'b0; end
        if (stop_pend) begin running <= 1'b0; stop_pend <= 1'b0; end
      end
      if (wr_dnxt) begin dnxt <= wval; dnxt_v <= 1'b1; end
      if (wr_pnxt) begin pnxt <= wval; pnxt_v <= 1'b1; end
      if (ena_req) begin
        if (!running) begin running <= 1'b1; cnt <= '0; end
        stop_pend <= 1'b0;
      end
      if (dis_req && running) stop_pend <= 1'b1;
      pin <= running ? ((cnt >= duty) ^ pol) : pol;
    end
  end

  // R4: counter stays inside the live period
  p_cnt_in_period_r4: assert property (@(posedge clk) disable iff (rst)
    (running && period != '0) |-> cnt < period);
  // R8: live settings are frozen while running except at a boundary
  p_live_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (running && !eop) |=> ($stable(duty) && $stable(period) && $stable(pres)));
  // R10: a channel only stops on a period boundary
  p_stop_on_eop_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(eop));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH      = 4,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int PRES_W   = 4,
  parameter int PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    pwm_out
);
  import pwm_bank_pkg::*;

  localparam int IDX_W    = ADDR_W - BANK_SH;
  localparam int BANK_END = BANK_BASE + (NCH << BANK_SH);

  logic              in_bank;
  logic [ADDR_W-1:0] bank_rel;
  logic [IDX_W-1:0]  bank_idx;
  logic [4:0]        bank_ofs;
  logic              hit_ena, hit_dis, hit_evt_rd;

  logic [NCH-1:0]    run_v, eop_v, pol_v, evt_q;
  logic [PRES_W-1:0] pres_a   [NCH];
  logic [CNT_W-1:0]  duty_a   [NCH];
  logic [CNT_W-1:0]  period_a [NCH];
  logic [DATA_W-1:0] rd_mux;
  logic              unused_bits;

  assign in_bank   = (int'(addr) >= BANK_BASE) && (int'(addr) < BANK_END);
  assign bank_rel  = addr - ADDR_W'(BANK_BASE);
  assign bank_idx  = bank_rel[ADDR_W-1:BANK_SH];
  assign bank_ofs  = addr[4:0];
  assign hit_ena   = wr_en && (addr == ADDR_W'(OFS_ENA));
  assign hit_dis   = wr_en && (addr == ADDR_W'(OFS_DIS));
  assign hit_evt_rd = rd_en && (addr == ADDR_W'(OFS_EVT));
  assign unused_bits = ^{wdata[DATA_W-1:CNT_W], bank_rel[BANK_SH-1:0]};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = wr_en && in_bank && (bank_idx == IDX_W'(i));

    pwm_bank_chan #(.CNT_W(CNT_W), .PRES_W(PRES_W), .PRES_MAX(PRES_MAX)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .ena_req (hit_ena && wdata[i]),
      .dis_req (hit_dis && wdata[i]),
      .wr_mode (sel && bank_ofs == 5'(BOFS_MODE)),
      .wr_duty (sel && bank_ofs == 5'(BOFS_DUTY)),
      .wr_per  (sel && bank_ofs == 5'(BOFS_PER)),
      .wr_dnxt (sel && bank_ofs == 5'(BOFS_DNXT)),
      .wr_pnxt (sel && bank_ofs == 5'(BOFS_PNXT)),
      .wval    (wdata[CNT_W-1:0]),
      .wpres   (wdata[PRES_W-1:0]),
      .wpol    (wdata[POL_BIT]),
      .running (run_v[i]),
      .eop     (eop_v[i]),
      .pol     (pol_v[i]),
      .pres    (pres_a[i]),
      .duty    (duty_a[i]),
      .period  (period_a[i]),
      .pin     (pwm_out[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(OFS_STAT))     rd_mux[NCH-1:0] = run_v;
    else if (addr == ADDR_W'(OFS_EVT)) rd_mux[NCH-1:0] = evt_q;
    else if (in_bank) begin
      for (int i = 0; i < NCH; i++) begin
        if (bank_idx == IDX_W'(i)) begin
          case (bank_ofs)
            5'(BOFS_MODE): begin
              rd_mux[PRES_W-1:0] = pres_a[i];
              rd_mux[POL_BIT]    = pol_v[i];
            end
            5'(BOFS_DUTY): rd_mux[CNT_W-1:0] = duty_a[i];
            5'(BOFS_PER):  rd_mux[CNT_W-1:0] = period_a[i];
            default:       rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      evt_q <= '0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      evt_q <= hit_evt_rd ? eop_v : (evt_q | eop_v);
    end
  end

  // R11: reading the event word with no new event leaves it empty
  p_evt_rdclr_r11: assert property (@(posedge clk) disable iff (rst)
    (hit_evt_rd && eop_v == '0) |=> evt_q == '0);
  // R11: an end of period always shows in the event word next cycle
  p_evt_set_r11: assert property (@(posedge clk) disable iff (rst)
    (eop_v != '0) |=> ((evt_q & $past(eop_v)) == $past(eop_v)));
endmodule

// File: tb/pwm_bank_test.sv
`timescale 1ns/1ps
module pwm_bank_test;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm_out;

  int tests = 0, fails = 0;
  int cyc = 0;
  bit done = 0;

  pwm_bank uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bank(input int ch, input int ofs);
    return 'h200 + ch * 'h20 + ofs;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 12'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); rd_en = 1'b1; addr = 12'(a);
    @(negedge clk); rd_en = 1'b0; d = int'(rdata);
  endtask

  task automatic wait_stop(input int ch);
    int s;
    for (int k = 0; k < 3000; k++) begin
      rd('h0C, s);
      if (s[ch] == 1'b0) break;
    end
  endtask

  task automatic wait_evt(input int ch);
    int s;
    for (int k = 0; k < 3000; k++) begin
      rd('h1C, s);
      if (s[ch]) break;
    end
  endtask

  task automatic measure(input int ch, input int n, output int hi, output int rises);
    logic prev, cur;
    hi = 0; rises = 0;
    @(negedge clk); prev = pwm_out[ch];
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cur = pwm_out[ch];
      if (cur) hi++;
      if (cur && !prev) rises++;
      prev = cur;
    end
  endtask

  task automatic run_case(input int ch, input int pres, input int per, input int dty,
                          input int pol, input string tag);
    int s, hi, rises, peff, t, act, eff_p;
    eff_p = (pres > 10) ? 10 : pres;
    peff = (per == 0) ? 1 : per;
    t = peff << eff_p;
    act = (dty < peff) ? ((peff - dty) << eff_p) : 0;
    wr(bank(ch, 'h00), (pol << 9) | pres);
    wr(bank(ch, 'h04), dty);
    wr(bank(ch, 'h0C), per);
    wr('h04, 1 << ch);
    rd('h0C, s);
    check("R9 status after enable", s[ch], 1);
    measure(ch, 2 * t, hi, rises);
    check({tag, " high cycles"}, hi, pol ? (2 * t - 2 * act) : 2 * act);
    if (!pol) check({tag, " rising edges"}, rises, (dty > 0 && dty < peff) ? 2 : 0);
    wr('h08, 1 << ch);
    wait_stop(ch);
    repeat (2) @(negedge clk);
    check("R5 R10 idle level after stop", pwm_out[ch], pol);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v, t0, el;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pins low", int'(pwm_out), 0);
    rd('h0C, v); check("R1 status", v, 0);
    rd('h1C, v); check("R1 event word", v, 0);
    rd(bank(0, 'h00), v); check("R1 mode", v, 0);
    rd(bank(2, 'h04), v); check("R1 duty", v, 0);
    rd(bank(3, 'h0C), v); check("R1 period", v, 0);

    // R3 clamp, R6 truncation, R2 bank decode
    wr(bank(3, 'h00), 15); rd(bank(3, 'h00), v); check("R3 prescale clamp", v, 10);
    wr(bank(3, 'h00), (1 << 9) | 3); rd(bank(3, 'h00), v); check("R5 R2 mode readback", v, 'h203);
    wr(bank(3, 'h0C), 'h0001_0007); rd(bank(3, 'h0C), v); check("R6 period truncated", v, 7);
    wr(bank(3, 'h04), 'h1234); rd(bank(0, 'h04), v); check("R2 bank isolation", v, 0);
    rd(bank(3, 'h04), v); check("R2 R8 duty loads when stopped", v, 'h1234);

    // R12 unmapped and update registers
    wr(bank(1, 'h14), 99); wr('h280, 77); wr('h010, 15);
    rd(bank(1, 'h14), v); check("R12 unmapped in bank", v, 0);
    rd('h280, v); check("R12 past last bank", v, 0);
    rd('h000, v); check("R12 low unmapped", v, 0);
    rd('h0C, v); check("R12 stray write starts nothing", v, 0);
    wr(bank(1, 'h08), 5); rd(bank(1, 'h08), v); check("R12 update reg reads 0", v, 0);
    rd(bank(1, 'h04), v); check("R12 R7 stopped update not live", v, 0);

    // R4 R5 R3 sweep: prescale x period x duty x polarity
    for (int pr = 0; pr < 3; pr++)
      for (int p = 0; p < 6; p++)
        for (int d = 0; d <= p + 1; d++)
          for (int po = 0; po < 2; po++)
            run_case(0, pr, p, d, po, "R4 R3 sweep");
    run_case(2, 10, 2, 1, 0, "R3 max prescale");
    run_case(3, 15, 2, 1, 0, "R3 clamped prescale");

    // R7 buffered update, R8 live writes ignored while running
    wr(bank(2, 'h00), 0); wr(bank(2, 'h04), 5); wr(bank(2, 'h0C), 20);
    wr('h04, 1 << 2);
    rd('h1C, v);
    wait_evt(2);
    wr(bank(2, 'h08), 15); wr(bank(2, 'h10), 30);
    rd(bank(2, 'h04), v); check("R7 duty not live before boundary", v, 5);
    rd(bank(2, 'h0C), v); check("R7 period not live before boundary", v, 20);
    wait_evt(2);
    rd(bank(2, 'h04), v); check("R7 duty live after boundary", v, 15);
    rd(bank(2, 'h0C), v); check("R7 period live after boundary", v, 30);
    wr(bank(2, 'h04), 3); wr(bank(2, 'h00), 4);
    rd(bank(2, 'h04), v); check("R8 duty write ignored while running", v, 15);
    rd(bank(2, 'h00), v); check("R8 mode write ignored while running", v, 0);
    begin
      int hi, rises;
      measure(2, 60, hi, rises);
      check("R7 new waveform high cycles", hi, 30);
      check("R7 new waveform edges", rises, 2);
    end
    wr('h08, 1 << 2); wait_stop(2);

    // R10 disable waits for the boundary
    wr(bank(1, 'h00), 0); wr(bank(1, 'h04), 50); wr(bank(1, 'h0C), 100);
    wr('h04, 1 << 1);
    rd('h1C, v);
    wait_evt(1);
    wr('h08, 1 << 1);
    t0 = cyc;
    rd('h0C, v); check("R10 status held after disable", v[1], 1);
    rd('h1C, v);
    wait_stop(1);
    el = cyc - t0;
    check("R10 stop delayed to period end", int'(el >= 85 && el <= 105), 1);
    rd('h1C, v); check("R11 event at final boundary", v[1], 1);
    check("R10 pin inactive after stop", pwm_out[1], 0);

    // R11 read clears
    rd('h1C, v); check("R11 cleared by read", v, 0);
    wr('h04, 1 << 0);
    repeat (30) @(negedge clk);
    rd('h1C, v); check("R11 running channel sets event", v & 1, 1);
    wr('h08, 1); wait_stop(0);
    rd('h1C, v); rd('h1C, v); check("R11 second read empty", v, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule